// File: doc/BRIEF.md
# Section Alarm Serial Bus Transmitter

This block sends a section's per-frame alarm and protection-switching status out over a three-wire serial link made of a bit clock, a frame pulse and a data line. Each frame is 72 bits long, split into nine 8-bit time slots. At the nominal 576 kHz bit rate, one frame lasts exactly 125 µs, so the link stays locked to the SDH frame rate. All values arrive in parallel and already computed: the defect flags, the filtered K1, K2 and S1 bytes, the K1/K2 change and instability flags, and a remote error count. The block only packs these values and shifts them out.

The bit clock is derived from the system clock with a half-period divider, and all three outputs come from registers. Data and the frame pulse change only when the bit clock falls, so a receiver samples them on the rising edge. The parallel inputs are copied into a shadow register at the first bit of every frame. Each frame therefore carries values that all belong to the same instant.

Top module: `sal_tx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `ser_clk` is 1 and both `ser_frame` and `ser_data` are 0.
- R2: `ser_clk` is a square wave with a period of 2*HALF_DIV system clock cycles. It is high for HALF_DIV cycles and low for HALF_DIV cycles.
- R3: `ser_data` and `ser_frame` change only in the cycle in which `ser_clk` goes from 1 to 0.
- R4: A frame is 72 bit periods long. `ser_frame` is 1 during the first bit period of each frame and 0 during the other 71.
- R5: Slot 1 (frame bits 0-7, sent first) carries `defect_flags[4:0]` from bit 4 down to bit 0, followed by three 0 bits. The flag order is: RDI generation, signal fail, signal degrade, B1 error, B2 error.
- R6: Slot 2 carries `k1_rx` and slot 3 carries `k2_rx`, each sent most significant bit first.
- R7: Slot 4 carries `aps_state[3:0]` from bit 3 down to bit 0, followed by four 0 bits. The flag order is: K1 change, K2 change, K1 unstable, K2 unstable.
- R8: Slot 5 carries `s1_rx`, sent most significant bit first.
- R9: Slots 6 and 7 carry `rei_count` as a 16-bit field, sent most significant bit first. If REI_W is less than 16, the value is zero-extended at the top.
- R10: Slots 8 and 9 (frame bits 56-71) are always 0.
- R11: The inputs are sampled once, at the falling clock edge that starts a frame. Input changes made during a frame do not affect that frame and first appear in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| defect_flags | input | 5 | {RDI gen, signal fail, signal degrade, B1 error, B2 error} |
| k1_rx | input | 8 | Filtered received K1 byte |
| k2_rx | input | 8 | Filtered received K2 byte |
| aps_state | input | 4 | {K1 change, K2 change, K1 unstable, K2 unstable} |
| s1_rx | input | 8 | Filtered received S1 byte |
| rei_count | input | REI_W | Remote error indication count |
| ser_clk | output | 1 | Serial bit clock |
| ser_frame | output | 1 | Frame pulse, high during bit 0 |
| ser_data | output | 1 | Serial data |

## Verification
The bench builds the block with HALF_DIV = 2 and REI_W = 16. This gives 4 system cycles per bit and 288 per frame, so more than a dozen complete frames fit in a short run. With these values the bench can decode every slot of every frame, measure the high and low times of the bit clock and the frame length exactly, and place an input change in the middle of a frame to confirm that only the next frame picks it up. The full-width error count also lets the bench check the bit order across the slot 6/7 boundary.

// File: rtl/sal_tx_pkg.sv
`timescale 1ns/1ps
package sal_tx_pkg;
  localparam int SLOT_BITS   = 8;
  localparam int NUM_SLOTS   = 9;
  localparam int FRAME_BITS  = SLOT_BITS * NUM_SLOTS;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int DEF_W       = 5;
  localparam int APS_W       = 4;
  localparam int BYTE_W      = 8;
  localparam int REI_FIELD_W = 2 * SLOT_BITS;

  // Slot numbers (zero based, in transmission order).
  localparam int SLOT_DEF = 0;
  localparam int SLOT_K1  = 1;
  localparam int SLOT_K2  = 2;
  localparam int SLOT_APS = 3;
  localparam int SLOT_S1  = 4;
  localparam int SLOT_REI = 5;

  localparam int DEF_MSB = FRAME_BITS - 1 - SLOT_DEF * SLOT_BITS;
  localparam int K1_MSB  = FRAME_BITS - 1 - SLOT_K1  * SLOT_BITS;
  localparam int K2_MSB  = FRAME_BITS - 1 - SLOT_K2  * SLOT_BITS;
  localparam int APS_MSB = FRAME_BITS - 1 - SLOT_APS * SLOT_BITS;
  localparam int S1_MSB  = FRAME_BITS - 1 - SLOT_S1  * SLOT_BITS;
  localparam int REI_MSB = FRAME_BITS - 1 - SLOT_REI * SLOT_BITS;

  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef struct packed {
    logic [DEF_W-1:0]       defects;
    logic [BYTE_W-1:0]      k1;
    logic [BYTE_W-1:0]      k2;
    logic [APS_W-1:0]       aps;
    logic [BYTE_W-1:0]      s1;
    logic [REI_FIELD_W-1:0] rei;
  } status_t;

  // Frame bit FRAME_BITS-1 is sent first; unused positions stay zero.
  function automatic frame_t pack_frame(status_t st);
    frame_t f;
    f = '0;
    f[DEF_MSB -: DEF_W]       = st.defects;
    f[K1_MSB  -: BYTE_W]      = st.k1;
    f[K2_MSB  -: BYTE_W]      = st.k2;
    f[APS_MSB -: APS_W]       = st.aps;
    f[S1_MSB  -: BYTE_W]      = st.s1;
    f[REI_MSB -: REI_FIELD_W] = st.rei;
    return f;
  endfunction
endpackage

// File: rtl/sal_bit_clock.sv
`timescale 1ns/1ps
module sal_bit_clock #(
  parameter int HALF_DIV = 87
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] half_cnt;
  logic          sclk_q;
  logic          tick;

  assign tick = (half_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt <= '0;
      sclk_q   <= 1'b1;
    end else begin
      if (tick) begin
        half_cnt <= '0;
        sclk_q   <= ~sclk_q;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  assign sclk     = sclk_q;
  assign fall_evt = tick & sclk_q;
endmodule

// File: rtl/sal_frame_seq.sv
`timescale 1ns/1ps
module sal_frame_seq
  import sal_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] next_idx,
  output logic             wrap
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] bit_idx;
  logic             at_last;

  assign at_last = (bit_idx == LAST);
  assign wrap    = step & at_last;

  always_comb begin
    next_idx = bit_idx;
    if (step) next_idx = at_last ? '0 : bit_idx + 1'b1;
  end

  // Starts on the last index so the first falling edge opens frame bit 0.
  always_ff @(posedge clk) begin
    if (rst) bit_idx <= LAST;
    else     bit_idx <= next_idx;
  end
endmodule

// File: rtl/sal_frame_shadow.sv
`timescale 1ns/1ps
module sal_frame_shadow
  import sal_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    capture,
  input  status_t live,
  output frame_t  frame_view
);
  frame_t packed_live;
  frame_t shadow_q;

  assign packed_live = pack_frame(live);
  assign frame_view  = capture ? packed_live : shadow_q;

  always_ff @(posedge clk) begin
    if (rst)          shadow_q <= '0;
    else if (capture) shadow_q <= packed_live;
  end
endmodule

// File: rtl/sal_tx.sv
`timescale 1ns/1ps
module sal_tx
  import sal_tx_pkg::*;
#(
  parameter int HALF_DIV = 87,
  parameter int REI_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEF_W-1:0] defect_flags,
  input  logic [7:0]       k1_rx,
  input  logic [7:0]       k2_rx,
  input  logic [APS_W-1:0] aps_state,
  input  logic [7:0]       s1_rx,
  input  logic [REI_W-1:0] rei_count,
  output logic             ser_clk,
  output logic             ser_frame,
  output logic             ser_data
);
  logic             fall_evt;
  logic [IDX_W-1:0] next_idx;
  logic [IDX_W-1:0] rev_idx;
  logic             wrap;
  status_t          live;
  frame_t           frame_view;
  logic             data_q;
  logic             frame_q;

  always_comb begin
    live          = '0;
    live.defects  = defect_flags;
    live.k1       = k1_rx;
    live.k2       = k2_rx;
    live.aps      = aps_state;
    live.s1       = s1_rx;
    live.rei[REI_W-1:0] = rei_count;
  end

  sal_bit_clock #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (ser_clk),
    .fall_evt (fall_evt)
  );

  sal_frame_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .step     (fall_evt),
    .next_idx (next_idx),
    .wrap     (wrap)
  );

  sal_frame_shadow u_shadow (
    .clk        (clk),
    .rst        (rst),
    .capture    (wrap),
    .live       (live),
    .frame_view (frame_view)
  );

  assign rev_idx = IDX_W'(FRAME_BITS - 1) - next_idx;

  // Launch on the falling bit-clock edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= 1'b0;
      frame_q <= 1'b0;
    end else if (fall_evt) begin
      data_q  <= frame_view[rev_idx];
      frame_q <= (next_idx == '0);
    end
  end

  assign ser_data  = data_q;
  assign ser_frame = frame_q;
endmodule

// File: rtl/sal_tx_chk.sv
`timescale 1ns/1ps
module sal_tx_chk #(
  parameter int HALF_DIV   = 87,
  parameter int FRAME_BITS = 72,
  parameter int SLOT_BITS  = 8
) (
  input logic clk,
  input logic rst,
  input logic ser_clk,
  input logic ser_frame,
  input logic ser_data
);
  localparam int FW = $clog2(FRAME_BITS) + 1;

  logic          prev_clk, prev_frame, prev_data;
  logic          clk_seen, frame_seen;
  logic [31:0]   run_len;
  logic [FW-1:0] fcnt;
  logic          fell_now, frame_rise;

  assign fell_now   = prev_clk & ~ser_clk;
  assign frame_rise = ser_frame & ~prev_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk   <= 1'b1;
      prev_frame <= 1'b0;
      prev_data  <= 1'b0;
      clk_seen   <= 1'b0;
      frame_seen <= 1'b0;
      run_len    <= '0;
      fcnt       <= '0;
    end else begin
      prev_clk   <= ser_clk;
      prev_frame <= ser_frame;
      prev_data  <= ser_data;
      if (ser_clk != prev_clk) begin
        run_len  <= '0;
        clk_seen <= 1'b1;
      end else begin
        run_len  <= run_len + 1;
      end
      if (fell_now) begin
        if (frame_rise) begin
          fcnt       <= '0;
          frame_seen <= 1'b1;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end
  end

  assert_clk_half_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_seen && ser_clk != prev_clk) |-> (run_len == 32'(HALF_DIV - 1)));

  assert_clk_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_seen && ser_clk == prev_clk) |-> (run_len < 32'(HALF_DIV - 1)));

  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_data != prev_data) |-> fell_now);

  assert_frame_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_frame != prev_frame) |-> fell_now);

  assert_frame_period_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_seen && frame_rise) |-> (fcnt == FW'(FRAME_BITS - 1)));

  assert_frame_width_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_seen && !ser_frame && prev_frame) |-> (fcnt == '0));

  assert_tail_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_seen && fell_now && !frame_rise &&
     fcnt >= FW'(FRAME_BITS - 2 * SLOT_BITS - 1)) |-> !ser_data);
endmodule

bind sal_tx sal_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_clk   (ser_clk),
  .ser_frame (ser_frame),
  .ser_data  (ser_data)
);

// File: tb/sim_sal_tx.sv
`timescale 1ns/1ps
module sim_sal_tx;
  localparam int HALF  = 2;
  localparam int REI_W = 16;
  localparam int NBITS = 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]       defect_flags = '0;
  logic [7:0]       k1_rx = '0, k2_rx = '0, s1_rx = '0;
  logic [3:0]       aps_state = '0;
  logic [REI_W-1:0] rei_count = '0;
  logic ser_clk, ser_frame, ser_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sal_tx #(.HALF_DIV(HALF), .REI_W(REI_W)) u0 (
    .clk(clk), .rst(rst), .defect_flags(defect_flags), .k1_rx(k1_rx),
    .k2_rx(k2_rx), .aps_state(aps_state), .s1_rx(s1_rx),
    .rei_count(rei_count), .ser_clk(ser_clk), .ser_frame(ser_frame),
    .ser_data(ser_data)
  );

  // Receiver model sampling on rising ser_clk, observed at negedge clk.
  logic prev_sclk = 1'b1, prev_data = 1'b0, prev_frm = 1'b0;
  logic [NBITS-1:0] rx_vec = '0, last_frame = '0;
  int rx_cnt = 0, frames_done = 0, rises = 0, cyc = 0, hi_cnt = 0;
  int edge_bad = 0, period_bad = 0, high_bad = 0, len_bad = 0;
  bit synced = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_sclk = 1'b1; prev_data = 1'b0; prev_frm = 1'b0;
      rx_cnt = 0; rises = 0; cyc = 0; hi_cnt = 0; synced = 0;
    end else begin
      if ((ser_data != prev_data || ser_frame != prev_frm) && !(prev_sclk && !ser_clk))
        edge_bad++;
      cyc++;
      if (prev_sclk && !ser_clk && rises > 0 && hi_cnt != HALF) high_bad++;
      if (ser_clk && prev_sclk) hi_cnt++;
      if (ser_clk && !prev_sclk) begin
        if (rises > 0 && cyc != 2 * HALF) period_bad++;
        cyc = 0; hi_cnt = 1; rises++;
        if (ser_frame) begin
          if (synced && rx_cnt != NBITS) len_bad++;
          synced = 1; rx_cnt = 1;
          rx_vec = {{(NBITS-1){1'b0}}, ser_data};
        end else if (synced) begin
          if (rx_cnt >= NBITS) len_bad++;
          else begin
            rx_vec = {rx_vec[NBITS-2:0], ser_data};
            rx_cnt++;
            if (rx_cnt == NBITS) begin
              last_frame = rx_vec;
              frames_done++;
            end
          end
        end
      end
      prev_sclk = ser_clk; prev_data = ser_data; prev_frm = ser_frame;
    end
  end

  function automatic logic [NBITS-1:0] exp_frame(logic [4:0] d, logic [7:0] k1,
      logic [7:0] k2, logic [3:0] a, logic [7:0] s1, logic [15:0] rei);
    return {d, 3'b000, k1, k2, a, 4'b0000, s1, rei, 16'h0000};
  endfunction

  task automatic chk(bit ok, string req, logic [NBITS-1:0] act, logic [NBITS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_frames(int n);
    for (int i = 0; i < n; i++) begin
      int f = frames_done;
      while (frames_done == f) @(negedge clk);
    end
  endtask

  task automatic apply(logic [4:0] d, logic [7:0] k1, logic [7:0] k2,
      logic [3:0] a, logic [7:0] s1, logic [15:0] rei);
    @(negedge clk);
    defect_flags = d; k1_rx = k1; k2_rx = k2; aps_state = a; s1_rx = s1; rei_count = rei;
  endtask

  task automatic check_slots(logic [NBITS-1:0] got, logic [NBITS-1:0] exp);
    for (int i = 0; i < 9; i++) begin
      string req;
      case (i)
        0:       req = "R5 slot1";
        1, 2:    req = "R6 K slot";
        3:       req = "R7 slot4";
        4:       req = "R8 slot5";
        5, 6:    req = "R9 rei slot";
        default: req = "R10 tail slot";
      endcase
      chk(got[NBITS-1-8*i -: 8] == exp[NBITS-1-8*i -: 8], req,
          NBITS'(got[NBITS-1-8*i -: 8]), NBITS'(exp[NBITS-1-8*i -: 8]));
    end
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk(ser_clk == 1'b1, "R1 clk in reset", NBITS'(ser_clk), NBITS'(1));
    chk(ser_frame == 1'b0, "R1 frame in reset", NBITS'(ser_frame), '0);
    chk(ser_data == 1'b0, "R1 data in reset", NBITS'(ser_data), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_clk == 1'b1 && !ser_frame && !ser_data, "R1 after release",
        NBITS'({ser_clk, ser_frame, ser_data}), NBITS'(3'b100));
  endtask

  task automatic test_pattern(logic [4:0] d, logic [7:0] k1, logic [7:0] k2,
      logic [3:0] a, logic [7:0] s1, logic [15:0] rei);
    logic [NBITS-1:0] e;
    e = exp_frame(d, k1, k2, a, s1, rei);
    apply(d, k1, k2, a, s1, rei);
    wait_frames(2);
    check_slots(last_frame, e);
  endtask

  task automatic test_timing();
    wait_frames(3);
    chk(period_bad == 0, "R2 clock period", NBITS'(period_bad), '0);
    chk(high_bad == 0, "R2 clock high time", NBITS'(high_bad), '0);
    chk(edge_bad == 0, "R3 change off falling edge", NBITS'(edge_bad), '0);
    chk(len_bad == 0, "R4 frame length", NBITS'(len_bad), '0);
  endtask

  task automatic test_shadow();
    logic [NBITS-1:0] ea, eb;
    ea = exp_frame(5'b10101, 8'h3C, 8'hC3, 4'b1001, 8'h5A, 16'h1234);
    eb = exp_frame(5'b01010, 8'hE7, 8'h18, 4'b0110, 8'hA5, 16'hFEDC);
    apply(5'b10101, 8'h3C, 8'hC3, 4'b1001, 8'h5A, 16'h1234);
    wait_frames(2);
    while (rx_cnt != 30) @(negedge clk);
    apply(5'b01010, 8'hE7, 8'h18, 4'b0110, 8'hA5, 16'hFEDC);
    wait_frames(1);
    chk(last_frame == ea, "R11 frame kept old values", last_frame, ea);
    wait_frames(1);
    chk(last_frame == eb, "R11 next frame new values", last_frame, eb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    test_reset();
    test_pattern(5'b11111, 8'hFF, 8'hFF, 4'b1111, 8'hFF, 16'hFFFF);
    test_pattern(5'b10000, 8'h81, 8'h7E, 4'b1000, 8'h01, 16'h8001);
    test_pattern(5'b00001, 8'hA5, 8'h5A, 4'b0001, 8'hC0, 16'h00FF);
    test_pattern(5'b00000, 8'h00, 8'h00, 4'b0000, 8'h00, 16'h0000);
    test_shadow();
    test_timing();
    finish_run();
  end
endmodule